// File: doc/BRIEF.md
# Write-Protected Seconds Counter

This block keeps a 32-bit count of elapsed seconds. A single-cycle tick strobe, produced elsewhere once per second, advances the count by one. Software sees the count as two 16-bit halves on a small register bus with an address, a write strobe, write data and combinational read data.

The count can be overwritten only while a one-bit arm flag is set. Software sets the flag, writes the low half, then writes the high half. The high-half write also clears the flag, so each load is a deliberate two-step sequence and a stray write cannot corrupt the time. Address map: 0 is the low half, 1 the high half, 2 the arm flag, and 3 is unused.

Top module: `sec_rtc_top`

## Requirements
- R1: After synchronous reset the count is 0x5BFC8900 and the arm flag is 0.
- R2: Reading address 0 returns count bits 15:0. Reading address 1 returns count bits 31:16.
- R3: A write to address 2 stores bit 0 of the write data as the arm flag. Reading address 2 returns the flag in bit 0, with bits 15:1 zero.
- R4: A write to address 0 replaces count bits 15:0 when the arm flag is 1. When the flag is 0, the count is left unchanged.
- R5: A write to address 1 replaces count bits 31:16 when the arm flag is 1, and the same write clears the flag. When the flag is 0, the count is left unchanged and the flag stays 0.
- R6: A cycle with tick high and no accepted count write increments the count by one. The count wraps from 0xFFFFFFFF to 0x00000000.
- R7: When an accepted count write and a tick fall in the same cycle, the write takes effect and that tick is dropped.
- R8: Address 3 reads as zero, and a write to it changes neither the count nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle strobe, once per second |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for addr_i, combinational |

## Verification
Every register is readable, so an internal error appears at the ports within one clock.

- A wrong count value shows on the next read of either half.
- An arm flag stuck high lets a write that should be ignored alter the count.
- An arm flag that fails to clear reads back as 1 at address 2 right after a high-half load.
- A lost or doubled tick drifts the count from the reference model on the next cycle.
- A bad carry appears when the low half passes 0xFFFF or the whole count wraps.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_ARM  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam logic [31:0] RTC_RESET_VAL = 32'h5BFC_8900;
endpackage

// File: rtl/sec_rtc_arm.sv
module sec_rtc_arm (
    input  logic clk,
    input  logic rst,
    input  logic set_wr_i,
    input  logic set_val_i,
    input  logic hi_wr_i,
    output logic arm_o
);
    typedef struct packed {
        logic arm;
    } arm_st_t;

    arm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_wr_i) begin
            st_d.arm = set_val_i;
        end else if (hi_wr_i) begin
            st_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arm_o = st_q.arm;

    assert_arm_store_R3: assert property (@(posedge clk) disable iff (rst)
        set_wr_i |=> (arm_o == $past(set_val_i)));

    assert_disarm_R5: assert property (@(posedge clk) disable iff (rst)
        (hi_wr_i && !set_wr_i) |=> !arm_o);
endmodule

// File: rtl/sec_rtc_count.sv
module sec_rtc_count #(
    parameter int          CNT_W     = 32,
    parameter logic [31:0] RESET_VAL = 32'h5BFC_8900
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick_i,
    input  logic                      arm_i,
    input  logic                      ld_lo_i,
    input  logic                      ld_hi_i,
    input  logic [CNT_W/2-1:0]        wdata_i,
    output logic [CNT_W-1:0]          cnt_o
);
    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    take_lo, take_hi;

    always_comb begin
        take_lo = ld_lo_i && arm_i;
        take_hi = ld_hi_i && arm_i;
        st_d    = st_q;
        if (take_lo) begin
            st_d.cnt[HALF_W-1:0] = wdata_i;
        end else if (take_hi) begin
            st_d.cnt[CNT_W-1:HALF_W] = wdata_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= RESET_VAL[CNT_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    assert_lo_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (ld_lo_i && !ld_hi_i && !arm_i && !tick_i) |=> (cnt_o == $past(cnt_o)));

    assert_hi_load_R5: assert property (@(posedge clk) disable iff (rst)
        (ld_hi_i && arm_i) |=> (cnt_o[CNT_W-1:HALF_W] == $past(wdata_i)));

    assert_tick_inc_R6: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !((ld_lo_i || ld_hi_i) && arm_i)) |=> (cnt_o == $past(cnt_o) + ONE));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ld_lo_i && arm_i) |=> (cnt_o == {$past(cnt_o[CNT_W-1:HALF_W]), $past(wdata_i)}));
endmodule

// File: rtl/sec_rtc_rdmux.sv
module sec_rtc_rdmux
    import sec_rtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [1:0]          addr_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                arm_i,
    output logic [CNT_W/2-1:0]  rd_data_o
);
    localparam int HALF_W = CNT_W / 2;

    always_comb begin
        rd_data_o = '0;
        unique case (reg_sel_e'(addr_i))
            REG_LO:   rd_data_o = cnt_i[HALF_W-1:0];
            REG_HI:   rd_data_o = cnt_i[CNT_W-1:HALF_W];
            REG_ARM:  rd_data_o = {{(HALF_W-1){1'b0}}, arm_i};
            REG_NONE: rd_data_o = '0;
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/sec_rtc_top.sv
module sec_rtc_top
    import sec_rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic [1:0]  addr_i,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    output logic [15:0] rd_data_o
);
    localparam int CNT_W = 32;

    logic             wr_lo, wr_hi, wr_arm;
    logic             arm;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_lo  = wr_en_i && (reg_sel_e'(addr_i) == REG_LO);
        wr_hi  = wr_en_i && (reg_sel_e'(addr_i) == REG_HI);
        wr_arm = wr_en_i && (reg_sel_e'(addr_i) == REG_ARM);
    end

    sec_rtc_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .set_wr_i  (wr_arm),
        .set_val_i (wr_data_i[0]),
        .hi_wr_i   (wr_hi),
        .arm_o     (arm)
    );

    sec_rtc_count #(
        .CNT_W     (CNT_W),
        .RESET_VAL (RTC_RESET_VAL)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .arm_i   (arm),
        .ld_lo_i (wr_lo),
        .ld_hi_i (wr_hi),
        .wdata_i (wr_data_i),
        .cnt_o   (cnt)
    );

    sec_rtc_rdmux #(
        .CNT_W (CNT_W)
    ) u_rd (
        .addr_i    (addr_i),
        .cnt_i     (cnt),
        .arm_i     (arm),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: tb/sim_sec_rtc_top.sv
`timescale 1ns/1ps
module sim_sec_rtc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        we = 1'b0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    bit [31:0] m_cnt;
    bit        m_arm;

    always #5 clk = ~clk;

    sec_rtc_top u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .addr_i    (addr),
        .wr_en_i   (we),
        .wr_data_i (wdata),
        .rd_data_o (rdata)
    );

    function automatic bit [15:0] model_read(input bit [1:0] a);
        case (a)
            2'd0:    return m_cnt[15:0];
            2'd1:    return m_cnt[31:16];
            2'd2:    return {15'd0, m_arm};
            default: return 16'd0;
        endcase
    endfunction

    task automatic compare(input string req);
        bit [15:0] exp;
        exp = model_read(addr);
        tests++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, rdata, exp);
        end
    endtask

    // one clock with the given inputs, model updated, then compared
    task automatic step(input bit t, input bit [1:0] a, input bit w,
                        input bit [15:0] d, input string req);
        bit load;
        @(negedge clk);
        tick = t; addr = a; we = w; wdata = d;
        @(posedge clk);
        #1;
        load = w && m_arm && (a == 2'd0 || a == 2'd1);
        if (load && a == 2'd0) m_cnt[15:0] = d;
        else if (load && a == 2'd1) m_cnt[31:16] = d;
        else if (t) m_cnt = m_cnt + 32'd1;
        if (w && a == 2'd2) m_arm = d[0];
        else if (w && a == 2'd1) m_arm = 1'b0;
        #1;
        compare(req);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            tick = 1'b0; we = 1'b0; addr = 2'(i);
            #1;
            compare(req);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_cnt = 32'h5BFC_8900;
        m_arm = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_all("R1 R2 reset state");

        // R6: plain ticks
        for (int i = 0; i < 5; i++) step(1'b1, 2'd0, 1'b0, 16'd0, "R6 tick");
        step(1'b0, 2'd1, 1'b0, 16'd0, "R2 high read");

        // R4 / R5: disarmed writes ignored
        step(1'b0, 2'd0, 1'b1, 16'h1111, "R4 disarmed low write");
        step(1'b0, 2'd1, 1'b1, 16'h2222, "R5 disarmed high write");
        read_all("R4 R5 after disarmed writes");
        step(1'b1, 2'd0, 1'b1, 16'h3333, "R4 disarmed write with tick");

        // R3: arm stores bit 0 only
        step(1'b0, 2'd2, 1'b1, 16'hFFFE, "R3 arm write bit0=0");
        step(1'b0, 2'd2, 1'b1, 16'h8003, "R3 arm write bit0=1");

        // R4 R5: armed low-then-high load and auto-disarm
        step(1'b0, 2'd0, 1'b1, 16'h1234, "R4 armed low write");
        step(1'b0, 2'd1, 1'b1, 16'hABCD, "R5 armed high write");
        read_all("R5 load and disarm");
        step(1'b0, 2'd1, 1'b1, 16'h5555, "R5 high write after disarm");
        step(1'b0, 2'd0, 1'b1, 16'h6666, "R4 low write after disarm");

        // R6: rollover
        step(1'b0, 2'd2, 1'b1, 16'h0001, "R3 arm");
        step(1'b0, 2'd0, 1'b1, 16'hFFFE, "R4 load low");
        step(1'b0, 2'd1, 1'b1, 16'hFFFF, "R5 load high");
        step(1'b1, 2'd0, 1'b0, 16'd0, "R6 tick to FFFFFFFF");
        step(1'b1, 2'd1, 1'b0, 16'd0, "R6 wrap high");
        step(1'b1, 2'd0, 1'b0, 16'd0, "R6 after wrap low");
        read_all("R6 after wrap");

        // R6: carry from low to high half
        step(1'b0, 2'd2, 1'b1, 16'h0001, "R3 arm");
        step(1'b0, 2'd0, 1'b1, 16'hFFFF, "R4 load low");
        step(1'b0, 2'd1, 1'b1, 16'h0010, "R5 load high");
        step(1'b1, 2'd1, 1'b0, 16'd0, "R6 half carry");

        // R7: write wins over tick
        step(1'b0, 2'd2, 1'b1, 16'h0001, "R3 arm");
        step(1'b1, 2'd0, 1'b1, 16'h0700, "R7 low write with tick");
        step(1'b1, 2'd1, 1'b1, 16'h0042, "R7 high write with tick");
        read_all("R7 after collisions");

        // R8: unused address
        step(1'b0, 2'd2, 1'b1, 16'h0001, "R3 arm");
        step(1'b0, 2'd3, 1'b1, 16'hFFFF, "R8 unused write");
        read_all("R8 after unused write");

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1; we = 1'b0; tick = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 32'h5BFC_8900;
        m_arm = 1'b0;
        read_all("R1 second reset");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule